// File: doc/BRIEF.md
# Single-Select SPI Word Master

This block is a register-mapped serial master that moves one 8-bit or 16-bit word at a time over a four-wire SPI link. It drives one slave select line. Software picks the word size and the serial clock rate in a configuration register. It asserts the select through a control bit. A write to the transmit register starts a full-duplex exchange. When the exchange ends, software reads the received word and clears a completion flag.

The serial link always runs in mode 0. The clock idles low. The master presents each outgoing bit while the clock is low, and it samples the incoming bit on the rising edge. Bits travel most-significant first. The serial clock period is an even number N of system clocks, with N between 4 and 30. The word size and the rate are captured at the moment a word is launched, so configuration writes made during an exchange apply only to the next word.

Top module: `spi_word_master`

## Requirements
- R1: After reset, cs_n is 1, sck is 0 and mosi is 0, and every register reads zero.
- R2: The control register is at byte offset 0x00. Bit 0 is the select: writing 1 drives cs_n to 0 and writing 0 drives it to 1. Bit 0 reads back as written. Bit 1 is a read-only busy flag.
- R3: The configuration register is at offset 0x04. Bits [5:0] read back as written, and bits [31:6] read as zero whatever is written to them. Bit 5 set to 1 selects 16-bit words and set to 0 selects 8-bit words.
- R4: Let h be configuration bits [3:0], with h at least 2. Each serial clock period is 2*h system clocks, made of h cycles low followed by h cycles high. An exchange lasts bits*2*h cycles from the launching write. Between exchanges, sck stays low.
- R5: A value of h below 2 is treated as h = 2, which gives a period of 4 clocks.
- R6: A write to offset 0x08 launches the word in its low 8 or 16 bits, shifted out MSB first. mosi changes only on a falling edge of sck, or at launch. Offset 0x08 reads as zero.
- R7: Offset 0x0C holds the word collected from miso, sampled on each rising edge of sck, MSB first. It is zero-extended: bits [31:8] in 8-bit mode and bits [31:16] in 16-bit mode are zero. It changes only in the cycle an exchange completes.
- R8: Offset 0x10 reads 1 in bit 0 once an exchange has completed. Writing a value with bit 0 clear clears it. Writing a value with bit 0 set leaves it unchanged.
- R9: A write to offset 0x08 while busy is ignored. It alters neither the word being shifted nor the completion time.
- R10: Busy reads 1 from the clock after the launching write until the completing edge, and it reads 0 afterwards.
- R11: Offsets with no register (0x14, 0x18, 0x1C) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Active-low slave select |

## Verification
A launching write takes effect at clock edge P0. Busy then holds through edge P0+T-1, and at edge P0+T the received word, the cleared busy bit and the raised flag all appear together, where T = bits*2*h. For every exchange, the bench computes T from the configuration it wrote. It counts exactly T-1 edges and reads the registers just after that edge, expecting busy set, the flag clear and the previous received word. It then advances one more edge and expects the new results. A slave model on the serial pins supplies miso and captures mosi, so the bench compares the serial contents with both the launched word and the slave word.

// File: rtl/spi_word_master.sv
module spi_word_master #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);

  localparam int WORD_W = 16;
  localparam int HALF_W = 4;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] OFS_CFG   = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] OFS_TX    = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] OFS_RX    = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] OFS_CAUSE = ADDR_W'(5'h10);
  localparam logic [HALF_W-1:0] HALF_MIN  = HALF_W'(2);

  logic              sel_q, busy_q, wide_q, sck_q, flag_q;
  logic [5:0]        cfg_q;
  logic [HALF_W-1:0] half_q, hcnt_q, half_sel;
  logic [CNT_W-1:0]  bit_q;
  logic [WORD_W-1:0] tx_q, rx_sh_q, rx_q;
  logic              wr_ctrl, wr_cfg, wr_tx, wr_cause, launch, tick, last, done;

  assign wr_ctrl  = bus_we && bus_addr == OFS_CTRL;
  assign wr_cfg   = bus_we && bus_addr == OFS_CFG;
  assign wr_tx    = bus_we && bus_addr == OFS_TX;
  assign wr_cause = bus_we && bus_addr == OFS_CAUSE;
  assign launch   = wr_tx && !busy_q;
  assign half_sel = (cfg_q[3:0] < HALF_MIN) ? HALF_MIN : cfg_q[3:0];
  assign tick     = busy_q && (hcnt_q == half_q - HALF_W'(1));
  assign last     = bit_q == (wide_q ? CNT_W'(WORD_W - 1) : CNT_W'(WORD_W/2 - 1));
  assign done     = tick && sck_q && last;

  assign sck  = sck_q;
  assign mosi = busy_q & tx_q[WORD_W-1];
  assign cs_n = ~sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      cfg_q   <= '0;
      busy_q  <= 1'b0;
      wide_q  <= 1'b0;
      half_q  <= HALF_MIN;
      hcnt_q  <= '0;
      bit_q   <= '0;
      sck_q   <= 1'b0;
      tx_q    <= '0;
      rx_sh_q <= '0;
    end else begin
      if (wr_ctrl) sel_q <= bus_wdata[0];
      if (wr_cfg)  cfg_q <= bus_wdata[5:0];
      if (launch) begin
        busy_q  <= 1'b1;
        wide_q  <= cfg_q[5];
        half_q  <= half_sel;
        hcnt_q  <= '0;
        bit_q   <= '0;
        sck_q   <= 1'b0;
        tx_q    <= cfg_q[5] ? bus_wdata[WORD_W-1:0] : {bus_wdata[7:0], 8'h00};
        rx_sh_q <= '0;
      end else if (busy_q) begin
        if (tick) begin
          hcnt_q <= '0;
          if (!sck_q) begin
            sck_q   <= 1'b1;
            rx_sh_q <= {rx_sh_q[WORD_W-2:0], miso};
          end else begin
            sck_q <= 1'b0;
            if (last) begin
              busy_q <= 1'b0;
            end else begin
              bit_q <= bit_q + CNT_W'(1);
              tx_q  <= {tx_q[WORD_W-2:0], 1'b0};
            end
          end
        end else begin
          hcnt_q <= hcnt_q + HALF_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      if (done) rx_q <= wide_q ? rx_sh_q : {8'h00, rx_sh_q[7:0]};
      if (done) flag_q <= 1'b1;
      else if (wr_cause && !bus_wdata[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL:  bus_rdata[1:0] = {busy_q, sel_q};
      OFS_CFG:   bus_rdata[5:0] = cfg_q;
      OFS_RX:    bus_rdata[WORD_W-1:0] = rx_q;
      OFS_CAUSE: bus_rdata[0] = flag_q;
      default:   bus_rdata = '0;
    endcase
  end

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);

  // R5
  sck_min_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && sck_q != $past(sck_q)) |=> (sck_q == $past(sck_q)));

  // R6
  mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && mosi != $past(mosi)) |-> (!sck_q && $past(sck_q)));

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy_q) |-> $stable(rx_q));

  // R8
  flag_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> flag_q);

  // R9
  no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_tx && !done) |=> (busy_q && bit_q >= $past(bit_q)));

endmodule

// File: tb/test_spi_word_master.sv
`timescale 1ns/1ps
module test_spi_word_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck, mosi, cs_n;
  logic [15:0] slv = '0;
  logic [15:0] cap = '0;
  logic [31:0] last_rx = '0;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  spi_word_master i_spi_word_master (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
    .miso(slv[15]), .cs_n(cs_n));

  always @(negedge sck) slv <= {slv[14:0], 1'b0};
  always @(posedge sck) cap <= {cap[14:0], mosi};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  function automatic int exp_cycles(input logic [5:0] cfg);
    int h = (cfg[3:0] < 2) ? 2 : int'(cfg[3:0]);
    return (cfg[5] ? 16 : 8) * 2 * h;
  endfunction

  task automatic exchange(input logic [5:0] cfg, input logic [15:0] w,
                          input logic [15:0] sw, input bit poke);
    logic [31:0] d;
    int total = exp_cycles(cfg);
    logic [31:0] mask = cfg[5] ? 32'hFFFF : 32'hFF;
    wr(5'h04, {26'h3FFFFFF, cfg});
    wr(5'h10, 32'h0);
    cap = '0;
    slv = cfg[5] ? sw : {sw[7:0], 8'h00};
    wr(5'h08, {16'hABCD, w});
    for (int i = 1; i < total; i++) begin
      if (poke && i == 2) begin
        bus_addr = 5'h08; bus_wdata = {16'h0, ~w}; bus_we = 1'b1;
      end
      @(posedge clk);
      #1 bus_we = 1'b0;
    end
    rd(5'h00, d); chk("R10 busy before end", {31'h0, d[1]}, 32'h1);
    rd(5'h10, d); chk("R8 flag not early", d, 32'h0);
    rd(5'h0C, d); chk("R7 rx held until end", d, last_rx);
    @(posedge clk);
    #1;
    rd(5'h00, d); chk("R10 busy clear at end", {31'h0, d[1]}, 32'h0);
    rd(5'h10, d); chk("R8 flag raised", d, 32'h1);
    rd(5'h0C, d); chk("R7 rx word", d, {16'h0, sw} & mask);
    chk(poke ? "R9 busy write ignored, mosi word" : "R6 mosi word MSB first",
        {16'h0, cap} & mask, {16'h0, w} & mask);
    last_rx = {16'h0, sw} & mask;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 cs_n", {31'h0, cs_n}, 32'h1);
    chk("R1 sck", {31'h0, sck}, 32'h0);
    chk("R1 mosi", {31'h0, mosi}, 32'h0);
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), d); chk("R1 reset read zero", d, 32'h0);
    end
    @(negedge clk) rst_n = 1'b1;
    wr(5'h00, 32'hFFFFFFFF);
    chk("R2 select asserted", {31'h0, cs_n}, 32'h0);
    rd(5'h00, d); chk("R2 ctrl readback", d, 32'h1);
    wr(5'h04, 32'hFFFFFFFF);
    rd(5'h04, d); chk("R3 cfg upper bits zero", d, 32'h3F);
    rd(5'h08, d); chk("R6 tx offset reads zero", d, 32'h0);
    for (int a = 20; a < 32; a += 4) begin
      rd(5'(a), d); chk("R11 unused offset zero", d, 32'h0);
    end
    exchange(6'h12, 16'h00A5, 16'h003C, 1'b0);
    exchange(6'h32, 16'h8001, 16'hF00F, 1'b0);
    exchange(6'h10, 16'h0081, 16'h00FF, 1'b0);
    exchange(6'h31, 16'h1234, 16'hFFFF, 1'b0);
    exchange(6'h1F, 16'h00FF, 16'h0000, 1'b0);
    exchange(6'h3F, 16'hFFFF, 16'h5AA5, 1'b0);
    exchange(6'h33, 16'hC3C3, 16'h1357, 1'b1);
    exchange(6'h04, 16'h0066, 16'h0099, 1'b1);
    wr(5'h10, 32'h1);
    rd(5'h10, d); chk("R8 write of 1 keeps flag", d, 32'h1);
    wr(5'h10, 32'hFFFFFFFE);
    rd(5'h10, d); chk("R8 write bit0 clear clears", d, 32'h0);
    for (int k = 0; k < 24; k++) begin
      logic [5:0] c;
      c[5] = 1'($urandom);
      c[4:0] = 5'($urandom);
      exchange(c, 16'($urandom), 16'($urandom), 1'($urandom % 4 == 0));
    end
    wr(5'h00, 32'hFFFFFFFE);
    chk("R2 select released", {31'h0, cs_n}, 32'h1);
    chk("R4 sck idle low", {31'h0, sck}, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule